// File: doc/BRIEF.md
# Lockable Shadowed PWM Duty Controller

This block drives one PWM output channel with 8-bit duty resolution. A host reaches the duty through one register address that behaves as two registers. Writes land in a hidden staging register, and reads return the current-duty register, which holds the duty the output is actually using. A free-running counter clocked by a prescaler tick sets the PWM period at 256 ticks. The current duty is reloaded only when that counter wraps to zero, so the output never changes shape in the middle of a period.

Four control inputs choose where the duty comes from at each period boundary. With start low, the duty is forced to full scale. With start high and manual mode selected, the staging value is used. With start high and manual mode not selected, the automatic-mode duty input is used. A lock input sets a sticky lock that only reset clears. While locked, every host write is dropped, and the staging register keeps its value. While the spin-up flag is high, the readback reports zero duty. The output itself is not affected by that flag.

Top module: `pwm_duty_shadow`

## Requirements
- R1: After reset the current-duty readback is 0xFF, the PWM output is high, and the staging register holds 0xFF.
- R2: The duty is linear in 8 bits. Over one 256-tick period the output is high for exactly `duty` ticks (0x00 gives 0 ticks, 0x40 gives 64, 0x80 gives 128). The value 0xFF holds the output high for all 256 ticks.
- R3: A host write sets the output duty only when manual mode is selected, start is 1 and the lock is clear.
- R4: While the lock is set, a host write has no effect, including on the staging register.
- R5: A write made while start is 0 or manual mode is off is still stored in staging. It takes effect at the first period boundary at which start is 1 and manual mode is selected.
- R6: At every period boundary with start at 0, the current duty becomes 0xFF. The readback then shows 0xFF and the output runs at 100%.
- R7: The current duty, and with it both the readback and the output, changes only at the boundary where the counter wraps to 0. A write or an automatic-duty change made mid-period is not visible until the next boundary.
- R8: While spin-up is 1, the readback is 0x00. The PWM output keeps using the current duty.
- R9: With start at 1 and manual mode off, the current duty takes the automatic-duty input at each boundary.
- R10: The lock is sticky. A one-cycle pulse on the lock input keeps writes blocked after the input falls, and only reset clears it.
- R11: `period_start` is high for exactly one clock in the cycle where the counter has just wrapped to 0. It fires once every 256 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaler tick; advances the period counter |
| wr_en | input | 1 | Host write strobe for the duty register |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current-duty readback |
| start | input | 1 | Enables duty control; 0 forces full duty |
| lock_in | input | 1 | Sets the sticky lock |
| manual_sel | input | 1 | Selects manual (host) duty source |
| auto_duty | input | 8 | Duty from the automatic fan algorithm |
| spinup | input | 1 | Spin-up in progress; readback shows 0 |
| pwm_out | output | 1 | PWM output |
| period_start | output | 1 | One-clock strobe at each period start |

## Verification
Two functions can fall into the same cycle. A host write or an automatic-duty change can arrive in the period that a boundary reload closes. The bench syncs to `period_start` and writes one tick after the wrap. It then samples the readback about a hundred ticks later, where the old value must still show, and again at the next strobe, where the new value must appear. A lock pulse can also meet a later write in the same period. That case is judged at the following boundary, where manual mode must still reload the value staged before the lock.

// File: rtl/pwmds_pkg.sv
// Package: shared types for the shadowed PWM duty channel.
// Assumes: nothing beyond IEEE 1800-2017.
package pwmds_pkg;

    // Duty source chosen at a period boundary.
    typedef enum logic [1:0] {
        SRC_FULL = 2'd0,   // start low: full duty
        SRC_HOST = 2'd1,   // manual mode: staging register
        SRC_AUTO = 2'd2    // automatic mode: external duty input
    } duty_src_e;

    // Pick the duty source from the gating inputs.
    function automatic duty_src_e pick_source(input logic start, input logic manual);
        if (!start)
            return SRC_FULL;
        else if (manual)
            return SRC_HOST;
        else
            return SRC_AUTO;
    endfunction

endpackage

// File: rtl/pwmds_period_timer.sv
// Module: pwmds_period_timer
// Counts prescaler ticks with a free-running W-bit counter. It flags the
// tick on which the counter wraps and registers a one-clock period strobe.
// Assumes: tick_en is a single-clock enable in the clk domain.
module pwmds_period_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         period_start
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         strobe_q;

    // Wrap event: a tick on the final count of the period.
    assign wrap = tick_en && (cnt_q == CNT_MAX);

    // Advance the period counter on each prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_en)
            cnt_q <= cnt_q + 1'b1;
    end

    // Register the strobe so it is high while the counter reads 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= wrap;
    end

    assign cnt          = cnt_q;
    assign period_start = strobe_q;
endmodule

// File: rtl/pwmds_host_regs.sv
// Module: pwmds_host_regs
// Holds the hidden staging register written by the host, and the sticky
// lock that blocks those writes until reset.
// Assumes: wr_en is a single-clock strobe; lock_in may be a pulse or a level.
module pwmds_host_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock_in,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] staging,
    output logic         locked
);
    localparam logic [W-1:0] FULL_DUTY = {W{1'b1}};

    logic [W-1:0] staging_q;
    logic         lock_q;
    logic         lock_eff;
    logic         wr_ok;

    // Lock takes hold in the same cycle as the input and stays afterwards.
    assign lock_eff = lock_q || lock_in;
    assign wr_ok    = wr_en && !lock_eff;

    // Sticky lock: only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (lock_in)
            lock_q <= 1'b1;
    end

    // Capture host writes while unlocked, whatever the mode and start state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            staging_q <= FULL_DUTY;
        else if (wr_ok)
            staging_q <= wr_data;
    end

    assign staging = staging_q;
    assign locked  = lock_q;
endmodule

// File: rtl/pwmds_duty_select.sv
// Module: pwmds_duty_select
// Chooses the duty source and loads the current-duty register only on a
// period wrap, so the value stays fixed for a whole period.
// Assumes: wrap is high for one clock per period.
module pwmds_duty_select
    import pwmds_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wrap,
    input  logic         start,
    input  logic         manual_sel,
    input  logic [W-1:0] staging,
    input  logic [W-1:0] auto_duty,
    output logic [W-1:0] cur_duty
);
    localparam logic [W-1:0] FULL_DUTY = {W{1'b1}};

    duty_src_e    src;
    logic [W-1:0] next_duty;
    logic [W-1:0] cur_q;

    // Decode which source feeds the next period.
    assign src = pick_source(start, manual_sel);

    // Mux the candidate duty for the coming period.
    always_comb begin
        unique case (src)
            SRC_HOST: next_duty = staging;
            SRC_AUTO: next_duty = auto_duty;
            default:  next_duty = FULL_DUTY;
        endcase
    end

    // Reload the current duty only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= FULL_DUTY;
        else if (wrap)
            cur_q <= next_duty;
    end

    assign cur_duty = cur_q;
endmodule

// File: rtl/pwmds_pwm_gen.sv
// Module: pwmds_pwm_gen
// Compares the period counter with the current duty. The output is high
// while the counter is below the duty; the full-scale code holds it high.
// Assumes: duty only changes when the counter wraps.
module pwmds_pwm_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty,
    output logic         pwm
);
    localparam logic [W-1:0] FULL_DUTY = {W{1'b1}};

    // Produce the PWM level from the compare.
    always_comb begin
        pwm = (duty == FULL_DUTY) || (cnt < duty);
    end
endmodule

// File: rtl/pwm_duty_shadow.sv
// Module: pwm_duty_shadow (top)
// One PWM channel. Host writes go to a hidden staging register; the current
// duty reloads at each period wrap from a source chosen by start and manual
// mode; a sticky lock blocks writes; spin-up forces the readback to zero.
// Assumes: synchronous active-low reset; tick_en from an external prescaler.
module pwm_duty_shadow #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [DUTY_W-1:0] rd_data,
    input  logic              start,
    input  logic              lock_in,
    input  logic              manual_sel,
    input  logic [DUTY_W-1:0] auto_duty,
    input  logic              spinup,
    output logic              pwm_out,
    output logic              period_start
);
    logic [DUTY_W-1:0] cnt;
    logic              wrap_evt;
    logic [DUTY_W-1:0] staging;
    logic              lock_q;
    logic [DUTY_W-1:0] cur_duty;

    pwmds_period_timer #(.W(DUTY_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .cnt          (cnt),
        .wrap         (wrap_evt),
        .period_start (period_start)
    );

    pwmds_host_regs #(.W(DUTY_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_in (lock_in),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .staging (staging),
        .locked  (lock_q)
    );

    pwmds_duty_select #(.W(DUTY_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap_evt),
        .start      (start),
        .manual_sel (manual_sel),
        .staging    (staging),
        .auto_duty  (auto_duty),
        .cur_duty   (cur_duty)
    );

    pwmds_pwm_gen #(.W(DUTY_W)) u_gen (
        .cnt  (cnt),
        .duty (cur_duty),
        .pwm  (pwm_out)
    );

    // Readback: zero during spin-up, otherwise the current duty.
    assign rd_data = spinup ? '0 : cur_duty;
endmodule

// File: rtl/pwmds_checker.sv
// Module: pwmds_checker
// Concurrent checks on the PWM duty channel, bound to the top module.
// Assumes: connected to the top's internal wrap, lock and duty state.
module pwmds_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wrap_evt,
    input logic         start,
    input logic         wr_en,
    input logic         spinup,
    input logic         lock_q,
    input logic [W-1:0] staging,
    input logic [W-1:0] cur_duty,
    input logic [W-1:0] rd_data,
    input logic         pwm_out,
    input logic         period_start
);
    localparam logic [W-1:0] FULL_DUTY = {W{1'b1}};

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_evt |=> $stable(cur_duty));

    assert_no_start_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && !start) |=> (cur_duty == FULL_DUTY));

    assert_locked_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_en) |=> $stable(staging));

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_spinup_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spinup |-> (rd_data == '0));

    assert_full_duty_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_duty == FULL_DUTY) |-> pwm_out);

    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);
endmodule

bind pwm_duty_shadow pwmds_checker #(.W(DUTY_W)) u_pwmds_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrap_evt     (wrap_evt),
    .start        (start),
    .wr_en        (wr_en),
    .spinup       (spinup),
    .lock_q       (lock_q),
    .staging      (staging),
    .cur_duty     (cur_duty),
    .rd_data      (rd_data),
    .pwm_out      (pwm_out),
    .period_start (period_start)
);

// File: tb/test_pwm_duty_shadow.sv
`timescale 1ns/1ps
module test_pwm_duty_shadow;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       start = 1'b0;
    logic       lock_in = 1'b0;
    logic       manual_sel = 1'b0;
    logic [7:0] auto_duty = '0;
    logic       spinup = 1'b0;
    logic       pwm_out;
    logic       period_start;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pwm_duty_shadow i_pwm_duty_shadow (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .start(start),
        .lock_in(lock_in), .manual_sel(manual_sel), .auto_duty(auto_duty),
        .spinup(spinup), .pwm_out(pwm_out), .period_start(period_start)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Advance to the negedge where period_start is high (counter reads 0).
    task automatic to_boundary();
        @(negedge clk);
        while (!period_start) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count high samples over one period, starting at counter 0.
    task automatic count_high(output int n);
        n = 0;
        repeat (256) begin
            if (pwm_out) n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 readback after reset", rd_data, 8'hFF);
        check("R1 pwm high after reset", pwm_out, 1);
        start = 1'b1; manual_sel = 1'b1;
        to_boundary();
        check("R1 staging holds 0xFF", rd_data, 8'hFF);
    endtask

    task automatic t_encoding();
        int n;
        to_boundary(); host_write(8'h40);
        to_boundary(); check("R3 manual write applied", rd_data, 8'h40);
        count_high(n); check("R2 0x40 gives 64 high ticks", n, 64);
        host_write(8'h80);
        to_boundary(); count_high(n); check("R2 0x80 gives 128 high ticks", n, 128);
        host_write(8'h00);
        to_boundary(); count_high(n); check("R2 0x00 gives no high ticks", n, 0);
        host_write(8'hFF);
        to_boundary(); count_high(n); check("R2 0xFF always high", n, 256);
    endtask

    task automatic t_period_align();
        int n;
        to_boundary(); host_write(8'h20);
        repeat (100) @(negedge clk);
        check("R7 mid-period readback unchanged", rd_data, 8'hFF);
        check("R11 no strobe mid-period", period_start, 0);
        to_boundary();
        check("R7 new duty at boundary", rd_data, 8'h20);
        check("R11 counter at 0 on strobe", pwm_out, 1);
        @(negedge clk);
        check("R11 strobe lasts one clock", period_start, 0);
        n = 1;
        while (!period_start) begin @(negedge clk); n++; end
        check("R11 strobe spacing 256", n, 256);
    endtask

    task automatic t_staged_when_stopped();
        int n;
        start = 1'b0; manual_sel = 1'b1;
        to_boundary(); host_write(8'h33);
        to_boundary();
        check("R6 start=0 reads 0xFF", rd_data, 8'hFF);
        count_high(n); check("R6 start=0 full duty", n, 256);
        manual_sel = 1'b0;
        to_boundary();
        check("R6 auto and start=0 reads 0xFF", rd_data, 8'hFF);
        start = 1'b1; manual_sel = 1'b1;
        to_boundary();
        check("R5 staged write active later", rd_data, 8'h33);
    endtask

    task automatic t_auto();
        int n;
        start = 1'b1; manual_sel = 1'b0; auto_duty = 8'h90;
        host_write(8'h55);
        to_boundary();
        check("R9 auto duty taken", rd_data, 8'h90);
        repeat (10) @(negedge clk);
        auto_duty = 8'h10;
        repeat (50) @(negedge clk);
        check("R7 auto change held mid-period", rd_data, 8'h90);
        to_boundary();
        check("R9 auto duty follows input", rd_data, 8'h10);
        count_high(n); check("R9 auto duty on output", n, 16);
        manual_sel = 1'b1;
        to_boundary();
        check("R5 write in auto mode staged", rd_data, 8'h55);
    endtask

    task automatic t_spinup();
        int n;
        spinup = 1'b1;
        @(negedge clk);
        check("R8 spin-up reads 0x00", rd_data, 8'h00);
        to_boundary(); count_high(n);
        check("R8 spin-up leaves output alone", n, 8'h55);
        spinup = 1'b0;
        @(negedge clk);
        check("R8 readback restored", rd_data, 8'h55);
    endtask

    task automatic t_lock();
        lock_in = 1'b1;
        @(negedge clk);
        lock_in = 1'b0;
        host_write(8'h11);
        to_boundary();
        check("R4 locked write ignored", rd_data, 8'h55);
        start = 1'b0; host_write(8'h22);
        start = 1'b1;
        to_boundary(); to_boundary();
        check("R10 lock sticky, staging kept", rd_data, 8'h55);
        do_reset();
        host_write(8'h66);
        to_boundary();
        check("R10 reset clears lock", rd_data, 8'h66);
    endtask

    initial begin
        t_reset();
        t_encoding();
        t_period_align();
        t_staged_when_stopped();
        t_auto();
        t_spinup();
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule